// File: doc/BRIEF.md
# Interlaced Video Sync Timing Core

This block produces and tracks the line and field timing of interlaced standard-definition video. It runs on the double-pixel clock. A two-bit standard select picks 525-line timing (two codes), 625-line timing, or a sleep state. A role select decides what the block does with the sync signals. As the timing master it drives active-low horizontal and vertical sync pulses. As a slave it takes both syncs from outside, recovers the sample and line position from them, and tells the odd field from the even field.

In both roles the same sample counter and line counter give the position. Downstream logic reads the position counters, an odd-field flag and a blanking flag. A line-length error flag shows when the external horizontal sync does not arrive at the nominal line length. Each count is a parameter: line length, lines per frame, sync width and blanking extents.

Standard select encoding: `11` selects 525 lines, `01` selects 525 lines (alternate colour system, same timing), `10` selects 625 lines, `00` selects sleep.

Top module: `sync_timing_core`

## Requirements
- R1: In master mode, not sleeping, `sample_cnt` counts 0 up to L-1 and then wraps to 0. L is `SAMPLES_525` (default 1716) for codes `11` and `01`, and `SAMPLES_625` (default 1728) for code `10`.
- R2: In master mode, `hs_out_n` is low exactly while `sample_cnt` < `HSYNC_W` (default 64), so each pulse lasts `HSYNC_W` clocks.
- R3: In master mode, `vs_out_n` is low for two full lines, starting at one of two points. For the odd field it starts at line 0, sample 0, together with horizontal sync. For the even field it starts at line H, sample L/2, where H = (N-1)/2.
- R4: In master mode, `line_cnt` advances when `sample_cnt` wraps and itself wraps after N-1. N is `LINES_525` (default 525) or `LINES_625` (default 625). `field_odd` is high before line H, sample L/2, and low from that point on.
- R5: Code `00` (sleep) holds both counters at 0 from the next clock. It also holds `sync_err` at 0. In the same cycle it forces `hs_out_n` and `vs_out_n` high, `sync_oe` low, and `blank` and `field_odd` high.
- R6: In slave mode, after each clock edge that samples `hs_in_n` low when it was high on the edge before, `sample_cnt` reads 0 and `line_cnt` advances by one, wrapping after N-1.
- R7: In slave mode, a sampled falling edge of `vs_in_n` sets the field. If it comes on the same edge as a horizontal sync fall, or while `sample_cnt` < L/4, the block sets `line_cnt` to 0 and `field_odd` to 1 (odd field). Otherwise it sets `line_cnt` to H and `field_odd` to 0 (even field).
- R8: `blank` is high whenever `sample_cnt` < `HBLANK`, or `line_cnt` < `VBLANK`, or H <= `line_cnt` <= H+`VBLANK`.
- R9: In slave mode, from the second horizontal sync fall on, `sync_err` is updated at each fall. It goes to 1 if the line just ended was not exactly L samples long, and to 0 if it was. Master mode and sleep clear it.
- R10: `sync_oe` is high only in master mode while not sleeping. In slave mode, both sync outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 2 | Standard select / sleep code |
| master_sel | input | 1 | 1 = timing master, 0 = slave |
| hs_in_n | input | 1 | External horizontal sync (slave) |
| vs_in_n | input | 1 | External vertical sync (slave) |
| hs_out_n | output | 1 | Generated horizontal sync, active low |
| vs_out_n | output | 1 | Generated vertical sync, active low |
| sync_oe | output | 1 | High when the generated syncs should drive the shared lines |
| sample_cnt | output | 11 | Sample position within the line |
| line_cnt | output | 10 | Line position within the frame |
| field_odd | output | 1 | 1 during the odd field |
| blank | output | 1 | Horizontal or vertical blanking interval |
| sync_err | output | 1 | Last measured slave line length was off-nominal |

## Verification
The counters are registers, and every other output is decoded from them and from the select inputs with no further register. A counter result is due in the cycle after the edge that caused it. A select change shows on the decoded outputs in the same cycle. A slave sync edge is first sampled into a flop, so its effect reaches the counters one edge after the pin falls, and the field and error results appear together with that counter update. The bench's behavioural model advances on every rising edge and is compared with all outputs 1 ns after every falling edge. At that point the inputs are settled and the counter flops have updated.

// File: rtl/sync_timing_core.sv
module sync_timing_core #(
  parameter int SAMPLES_525 = 1716,
  parameter int SAMPLES_625 = 1728,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int HSYNC_W     = 64,
  parameter int HBLANK      = 276,
  parameter int VBLANK      = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  std_sel,
  input  logic        master_sel,
  input  logic        hs_in_n,
  input  logic        vs_in_n,
  output logic        hs_out_n,
  output logic        vs_out_n,
  output logic        sync_oe,
  output logic [$clog2((SAMPLES_625 > SAMPLES_525) ? SAMPLES_625 : SAMPLES_525)-1:0] sample_cnt,
  output logic [$clog2((LINES_625 > LINES_525) ? LINES_625 : LINES_525)-1:0]         line_cnt,
  output logic        field_odd,
  output logic        blank,
  output logic        sync_err
);
  localparam int SW = $clog2((SAMPLES_625 > SAMPLES_525) ? SAMPLES_625 : SAMPLES_525);
  localparam int LW = $clog2((LINES_625 > LINES_525) ? LINES_625 : LINES_525);

  logic sleep, pal, m_act;
  logic [SW-1:0] len, half_smp, quarter;
  logic [LW-1:0] nlines, half_ln;
  logic hs_q, vs_q, hs_fall, vs_fall, s_end, l_end;
  logic fo_q, seen_hs, fo_master, vs_win, vblk;

  assign sleep    = (std_sel == 2'b00);
  assign pal      = (std_sel == 2'b10);
  assign m_act    = master_sel && !sleep;
  assign len      = pal ? SW'(SAMPLES_625) : SW'(SAMPLES_525);
  assign nlines   = pal ? LW'(LINES_625) : LW'(LINES_525);
  assign half_ln  = pal ? LW'((LINES_625 - 1) / 2) : LW'((LINES_525 - 1) / 2);
  assign half_smp = len >> 1;
  assign quarter  = len >> 2;
  assign hs_fall  = hs_q && !hs_in_n;
  assign vs_fall  = vs_q && !vs_in_n;
  assign s_end    = (sample_cnt >= len - SW'(1));
  assign l_end    = (line_cnt >= nlines - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1; vs_q <= 1'b1;
      sample_cnt <= '0; line_cnt <= '0;
      fo_q <= 1'b1; sync_err <= 1'b0; seen_hs <= 1'b0;
    end else begin
      hs_q <= hs_in_n;
      vs_q <= vs_in_n;
      if (sleep) begin
        sample_cnt <= '0; line_cnt <= '0;
        fo_q <= 1'b1; sync_err <= 1'b0; seen_hs <= 1'b0;
      end else if (master_sel) begin
        sample_cnt <= s_end ? '0 : sample_cnt + SW'(1);
        if (s_end) line_cnt <= l_end ? '0 : line_cnt + LW'(1);
        sync_err <= 1'b0;
        seen_hs  <= 1'b0;
      end else begin
        sample_cnt <= (hs_fall || s_end) ? '0 : sample_cnt + SW'(1);
        if (vs_fall) begin
          if (hs_fall || sample_cnt < quarter) begin
            line_cnt <= '0;      fo_q <= 1'b1;
          end else begin
            line_cnt <= half_ln; fo_q <= 1'b0;
          end
        end else if (hs_fall) begin
          line_cnt <= l_end ? '0 : line_cnt + LW'(1);
        end
        if (hs_fall) begin
          seen_hs <= 1'b1;
          if (seen_hs) sync_err <= (sample_cnt != len - SW'(1));
        end
      end
    end
  end

  assign vs_win = (line_cnt < LW'(2))
               || (line_cnt == half_ln && sample_cnt >= half_smp)
               || (line_cnt == half_ln + LW'(1))
               || (line_cnt == half_ln + LW'(2) && sample_cnt < half_smp);
  assign fo_master = (line_cnt < half_ln) || (line_cnt == half_ln && sample_cnt < half_smp);
  assign vblk = (line_cnt < LW'(VBLANK))
             || (line_cnt >= half_ln && line_cnt <= half_ln + LW'(VBLANK));

  assign hs_out_n  = !(m_act && sample_cnt < SW'(HSYNC_W));
  assign vs_out_n  = !(m_act && vs_win);
  assign sync_oe   = m_act;
  assign field_odd = sleep ? 1'b1 : (master_sel ? fo_master : fo_q);
  assign blank     = sleep || (sample_cnt < SW'(HBLANK)) || vblk;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && sample_cnt == len - SW'(1)) |=> (sample_cnt == '0));

  p_odd_even_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act && $stable(std_sel) && $stable(master_sel) && $fell(vs_out_n))
      |-> (!hs_out_n || sample_cnt == half_smp));

  p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (hs_out_n && vs_out_n && blank && !sync_oe));

  p_resync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && !sleep && hs_fall) |=> (sample_cnt == '0));

  p_even_detect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && !sleep && vs_fall && !hs_fall && sample_cnt >= quarter)
      |=> (!field_odd || sleep || master_sel));

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel || sleep) |=> !sync_err);
endmodule

// File: tb/tb_sync_timing_core.sv
`timescale 1ns/100ps
module tb_sync_timing_core;
  localparam int S5 = 120, S6 = 132, N5 = 25, N6 = 31, HW = 8, HB = 20, VB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] std_sel = 2'b11;
  logic master_sel = 1'b1, hs_in_n = 1'b1, vs_in_n = 1'b1;
  logic hs_out_n, vs_out_n, sync_oe, field_odd, blank, sync_err;
  logic [7:0] sample_cnt;
  logic [4:0] line_cnt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_timing_core #(.SAMPLES_525(S5), .SAMPLES_625(S6), .LINES_525(N5), .LINES_625(N6),
                     .HSYNC_W(HW), .HBLANK(HB), .VBLANK(VB)) dut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .master_sel(master_sel),
    .hs_in_n(hs_in_n), .vs_in_n(vs_in_n), .hs_out_n(hs_out_n), .vs_out_n(vs_out_n),
    .sync_oe(sync_oe), .sample_cnt(sample_cnt), .line_cnt(line_cnt),
    .field_odd(field_odd), .blank(blank), .sync_err(sync_err));

  // behavioural reference state
  int ms = 0, ml = 0, mfo = 1, merr = 0, mseen = 0, mhq = 1, mvq = 1;

  function automatic int m_len();   return (std_sel == 2'b10) ? S6 : S5; endfunction
  function automatic int m_lines(); return (std_sel == 2'b10) ? N6 : N5; endfunction
  function automatic int m_half();  return (m_lines() - 1) / 2; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; ml = 0; mfo = 1; merr = 0; mseen = 0; mhq = 1; mvq = 1;
    end else begin
      automatic int L = m_len();
      automatic int N = m_lines();
      automatic bit hf = mhq && !hs_in_n;
      automatic bit vf = mvq && !vs_in_n;
      automatic int old_s = ms;
      if (std_sel == 2'b00) begin
        ms = 0; ml = 0; mfo = 1; merr = 0; mseen = 0;
      end else if (master_sel) begin
        if (ms >= L - 1) begin ms = 0; ml = (ml >= N - 1) ? 0 : ml + 1; end
        else ms = ms + 1;
        merr = 0; mseen = 0;
      end else begin
        ms = (hf || ms >= L - 1) ? 0 : ms + 1;
        if (vf) begin
          if (hf || old_s < L / 4) begin ml = 0; mfo = 1; end
          else begin ml = m_half(); mfo = 0; end
        end else if (hf) ml = (ml >= N - 1) ? 0 : ml + 1;
        if (hf) begin
          if (mseen) merr = (old_s != L - 1);
          mseen = 1;
        end
      end
      mhq = hs_in_n; mvq = vs_in_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      automatic bit slp = (std_sel == 2'b00);
      automatic bit act = master_sel && !slp;
      automatic int L = m_len();
      automatic int H = m_half();
      automatic bit vwin = (ml < 2) || (ml == H && ms >= L / 2) || (ml == H + 1)
                        || (ml == H + 2 && ms < L / 2);
      automatic bit fom = (ml < H) || (ml == H && ms < L / 2);
      automatic bit e_fo = slp ? 1'b1 : (master_sel ? fom : mfo[0]);
      automatic bit e_bl = slp || ms < HB || ml < VB || (ml >= H && ml <= H + VB);
      automatic string ts = slp ? "R5" : "";
      chk(slp ? "R5" : "R1", sample_cnt, ms);
      chk(slp ? "R5" : (master_sel ? "R4" : "R6"), line_cnt, ml);
      chk(slp ? "R5" : "R2", hs_out_n, !(act && ms < HW));
      chk(slp ? "R5" : "R3", vs_out_n, !(act && vwin));
      chk(slp ? "R5" : "R10", sync_oe, act);
      chk(slp ? "R5" : (master_sel ? "R4" : "R7"), field_odd, e_fo);
      chk(slp ? "R5" : "R8", blank, e_bl);
      chk(slp ? "R5" : "R9", sync_err, merr);
      if (ts.len() > 0 && errors < 0) $display("%s", ts);
    end
  end

  // external sync source for slave mode; short_line gets 10 fewer samples
  task automatic slave_frame(int nl, int L, int H, int short_line);
    for (int g = 0; g < nl; g++) begin
      automatic int len = (g == short_line) ? L - 10 : L;
      for (int s = 0; s < len; s++) begin
        @(negedge clk);
        hs_in_n = !(s < HW);
        vs_in_n = !(((g < 2) && s >= 3) || (g == 2 && s < 3) ||
                    (g == H && s >= L / 2) || (g == H + 1) || (g == H + 2 && s < L / 2));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R3 R4 R8 R10: master, 525 lines
    repeat (2 * N5 * S5 + 50) @(negedge clk);
    // R5: sleep, then R1/R4 625-line master from a clean start
    std_sel = 2'b00;
    repeat (30) @(negedge clk);
    std_sel = 2'b10;
    repeat (2 * N6 * S6 + 20) @(negedge clk);
    std_sel = 2'b00;
    repeat (5) @(negedge clk);
    std_sel = 2'b01;
    repeat (N5 * S5 + 10) @(negedge clk);
    // R6 R7 R9: slave, 525 lines, then a short line
    master_sel = 1'b0; std_sel = 2'b11;
    slave_frame(N5, S5, (N5 - 1) / 2, -1);
    slave_frame(N5, S5, (N5 - 1) / 2, -1);
    slave_frame(N5, S5, (N5 - 1) / 2, 7);
    // R6 R7 R9: slave, 625 lines
    std_sel = 2'b10;
    slave_frame(N6, S6, (N6 - 1) / 2, -1);
    slave_frame(N6, S6, (N6 - 1) / 2, 4);
    slave_frame(N6, S6, (N6 - 1) / 2, -1);
    // R5 in slave role, then back to master (R9 clear, R10)
    hs_in_n = 1'b1; vs_in_n = 1'b1;
    std_sel = 2'b00;
    repeat (40) @(negedge clk);
    master_sel = 1'b1; std_sel = 2'b11;
    repeat (200) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule